// File: doc/BRIEF.md
# Register Compare and Step Flag Unit

This block is the combinational part of an 8-bit processor datapath that handles three operations: comparing a register with an operand, incrementing a value, and decrementing a value. A 2-bit target code selects the accumulator, the X register, the Y register or a memory operand. The surrounding core supplies the current register contents and the fetched memory byte. It takes back the computed value, the processor-style negative, zero and carry flags, a mask that says which status bits to update, and a one-hot writeback enable.

A compare subtracts the memory operand from the selected register. It reports the result only through the flags and never requests a writeback. An increment or a decrement produces the new value modulo 2^WIDTH, updates only negative and zero, and writes back to exactly the location it read. The overflow flag is never part of the update mask.

The register file, the memory port and the instruction decoder sit outside the block. All outputs follow the inputs within the same cycle.

Top module: `cstep_unit`

## Requirements
- R1: For a compare (op_i = 01) with target 00, 01 or 10, c_o is 1 exactly when the selected register is greater than or equal to mem_i, both taken as unsigned.
- R2: For such a compare, z_o is 1 exactly when the selected register equals mem_i.
- R3: For such a compare, n_o equals the top bit of (register - mem_i) modulo 2^WIDTH; for example, 123 compared with 124 gives n_o = 1.
- R4: A compare never asserts any wb_o bit. Its fmask_o is 4'b1110, where bit 3 is N, bit 2 is Z, bit 1 is C and bit 0 is V.
- R5: Increment (op_i = 10) and decrement (op_i = 11) drive res_o with the source value plus or minus one modulo 2^WIDTH, so 0xFF steps up to 0x00 and 0x00 steps down to 0xFF. The source is acc_i, xr_i, yr_i or mem_i for target 00, 01, 10 or 11.
- R6: After an increment or decrement, n_o is the top bit of res_o and z_o is 1 exactly when res_o is zero. fmask_o is 4'b1100, so C and V stay untouched.
- R7: An increment or decrement sets exactly one wb_o bit: bit 0 for the accumulator, bit 1 for X, bit 2 for Y and bit 3 for memory, chosen by tgt_i. No other location is written.
- R8: The idle code (op_i = 00) and a compare with the memory target (tgt_i = 11) assert no wb_o bit and give fmask_o = 4'b0000.
- R9: fmask_o bit 0 (V) is 0 for every operation and target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 2 | Operation: 00 idle, 01 compare, 10 increment, 11 decrement |
| tgt_i | input | 2 | Target: 00 accumulator, 01 X, 10 Y, 11 memory |
| acc_i | input | WIDTH | Current accumulator value |
| xr_i | input | WIDTH | Current X register value |
| yr_i | input | WIDTH | Current Y register value |
| mem_i | input | WIDTH | Memory operand (compare subtrahend, or step source for target 11) |
| res_o | output | WIDTH | Stepped value, or the difference for a compare |
| n_o | output | 1 | Negative flag result |
| z_o | output | 1 | Zero flag result |
| c_o | output | 1 | Carry flag result (no-borrow of a compare) |
| fmask_o | output | 4 | Status bits to update: [3] N, [2] Z, [1] C, [0] V |
| wb_o | output | 4 | One-hot writeback enable: [0] acc, [1] X, [2] Y, [3] memory |

## Verification
The bench builds the unit with its default WIDTH of 8. At that width every source value, 0x00 through 0xFF, can be swept for each operation and target, so both wrap points and the 0x7F/0x80 sign boundary are always exercised. Each compare pairs the register with operands that are equal, one above, one below and at the extremes. This covers every outcome of the carry, zero and negative flags. Registers that are not selected carry different values, so any leak of a wrong source into the result or the flags becomes visible.

// File: rtl/cstep_pkg.sv
package cstep_pkg;

  localparam int OP_W   = 2;
  localparam int TGT_W  = 2;
  localparam int NTGT   = 1 << TGT_W;
  localparam int FLAG_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_IDLE = 2'b00,
    OP_CMP  = 2'b01,
    OP_INC  = 2'b10,
    OP_DEC  = 2'b11
  } op_e;

  typedef enum logic [TGT_W-1:0] {
    TGT_ACC = 2'b00,
    TGT_X   = 2'b01,
    TGT_Y   = 2'b10,
    TGT_MEM = 2'b11
  } tgt_e;

  localparam int FB_N = 3;
  localparam int FB_Z = 2;
  localparam int FB_C = 1;
  localparam int FB_V = 0;

endpackage

// File: rtl/cstep_srcsel.sv
module cstep_srcsel
  import cstep_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [TGT_W-1:0] tgt_i,
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] xr_i,
  input  logic [WIDTH-1:0] yr_i,
  input  logic [WIDTH-1:0] mem_i,
  output logic [WIDTH-1:0] src_o
);

  always_comb begin
    unique case (tgt_e'(tgt_i))
      TGT_ACC: src_o = acc_i;
      TGT_X:   src_o = xr_i;
      TGT_Y:   src_o = yr_i;
      default: src_o = mem_i;
    endcase
  end

endmodule

// File: rtl/cstep_adder.sv
module cstep_adder
  import cstep_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] lhs_i,
  input  logic [WIDTH-1:0] rhs_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  localparam int SUM_W = WIDTH + 1;

  logic [WIDTH-1:0] addend;
  logic             cin;
  logic [SUM_W-1:0] total;

  // one shared adder: compare adds the inverted operand plus one,
  // increment adds one, decrement adds all ones
  always_comb begin
    unique case (op_e'(op_i))
      OP_CMP: begin addend = ~rhs_i;        cin = 1'b1; end
      OP_INC: begin addend = '0;            cin = 1'b1; end
      OP_DEC: begin addend = '1;            cin = 1'b0; end
      default: begin addend = '0;           cin = 1'b0; end
    endcase
  end

  assign total  = {1'b0, lhs_i} + {1'b0, addend} + {{WIDTH{1'b0}}, cin};
  assign sum_o  = total[WIDTH-1:0];
  assign cout_o = total[WIDTH];

  // no-borrow from the adder must agree with an unsigned magnitude test
  always_comb begin
    if (op_e'(op_i) == OP_CMP)
      AST_CMP_CARRY: assert (cout_o == (lhs_i >= rhs_i)); // R1
  end

endmodule

// File: rtl/cstep_wbdec.sv
module cstep_wbdec
  import cstep_pkg::*;
(
  input  logic [OP_W-1:0]   op_i,
  input  logic [TGT_W-1:0]  tgt_i,
  output logic              cmp_ok_o,
  output logic [NTGT-1:0]   wb_o,
  output logic [FLAG_W-1:0] fmask_o
);

  logic step_op;

  assign step_op  = (op_e'(op_i) == OP_INC) || (op_e'(op_i) == OP_DEC);
  assign cmp_ok_o = (op_e'(op_i) == OP_CMP) && (tgt_e'(tgt_i) != TGT_MEM);

  for (genvar t = 0; t < NTGT; t++) begin : g_wb
    assign wb_o[t] = step_op && (tgt_i == TGT_W'(t));
  end

  always_comb begin
    fmask_o = '0;
    if (cmp_ok_o) begin
      fmask_o[FB_N] = 1'b1;
      fmask_o[FB_Z] = 1'b1;
      fmask_o[FB_C] = 1'b1;
    end else if (step_op) begin
      fmask_o[FB_N] = 1'b1;
      fmask_o[FB_Z] = 1'b1;
    end
  end

  always_comb begin
    AST_WB_ONEHOT: assert ($onehot0(wb_o)); // R7
    if (cmp_ok_o)
      AST_CMP_NO_WB: assert (wb_o == '0); // R4
  end

endmodule

// File: rtl/cstep_unit.sv
module cstep_unit
  import cstep_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [1:0]       op_i,
  input  logic [1:0]       tgt_i,
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] xr_i,
  input  logic [WIDTH-1:0] yr_i,
  input  logic [WIDTH-1:0] mem_i,
  output logic [WIDTH-1:0] res_o,
  output logic             n_o,
  output logic             z_o,
  output logic             c_o,
  output logic [3:0]       fmask_o,
  output logic [3:0]       wb_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] src;
  logic [WIDTH-1:0] sum;
  logic             cout;
  logic             cmp_ok;

  cstep_srcsel #(.WIDTH(WIDTH)) u_srcsel (
    .tgt_i (tgt_i),
    .acc_i (acc_i),
    .xr_i  (xr_i),
    .yr_i  (yr_i),
    .mem_i (mem_i),
    .src_o (src)
  );

  cstep_adder #(.WIDTH(WIDTH)) u_adder (
    .op_i   (op_i),
    .lhs_i  (src),
    .rhs_i  (mem_i),
    .sum_o  (sum),
    .cout_o (cout)
  );

  cstep_wbdec u_wbdec (
    .op_i     (op_i),
    .tgt_i    (tgt_i),
    .cmp_ok_o (cmp_ok),
    .wb_o     (wb_o),
    .fmask_o  (fmask_o)
  );

  assign res_o = sum;
  assign n_o   = sum[MSB];
  assign z_o   = (sum == '0);
  assign c_o   = cmp_ok & cout;

  always_comb begin
    if (cmp_ok && z_o)
      AST_CMP_EQ_CARRY: assert (c_o); // R2
    if (wb_o != '0)
      AST_STEP_MASK: assert (fmask_o == 4'b1100); // R6
    if (wb_o != '0)
      AST_STEP_NONZERO_SRC: assert (res_o != src); // R5
  end

endmodule

// File: tb/cstep_unit_tb_top.sv
module cstep_unit_tb_top;

  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic [1:0]   op;
  logic [1:0]   tgt;
  logic [W-1:0] acc, xr, yr, mem;
  logic [W-1:0] res;
  logic         n, z, c;
  logic [3:0]   fmask, wb;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  cstep_unit #(.WIDTH(W)) dut_i (
    .op_i(op), .tgt_i(tgt), .acc_i(acc), .xr_i(xr), .yr_i(yr), .mem_i(mem),
    .res_o(res), .n_o(n), .z_o(z), .c_o(c), .fmask_o(fmask), .wb_o(wb)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h op=%0d tgt=%0d a=%0h x=%0h y=%0h m=%0h",
               req, what, act, exp, op, tgt, acc, xr, yr, mem);
    end
  endtask

  // drive after the rising edge, compare just before the next one
  task automatic apply(input int o, input int t, input int a, input int x,
                       input int y, input int m);
    int src, exp_res, exp_mask, exp_wb;
    @(posedge clk);
    #1;
    op = o[1:0]; tgt = t[1:0];
    acc = a[7:0]; xr = x[7:0]; yr = y[7:0]; mem = m[7:0];
    @(negedge clk);
    src = (t == 0) ? a : (t == 1) ? x : (t == 2) ? y : m;
    chk("R9", "fmask_v", fmask[0], 0);
    if (o == 1 && t != 3) begin
      chk("R1", "c", c, (src >= m) ? 1 : 0);
      chk("R2", "z", z, (src == m) ? 1 : 0);
      chk("R3", "n", n, (((src - m) & 255) >= 128) ? 1 : 0);
      chk("R4", "wb", wb, 0);
      chk("R4", "fmask", fmask, 4'b1110);
    end else if (o == 2 || o == 3) begin
      exp_res = (o == 2) ? ((src + 1) & 255) : ((src + 255) & 255);
      exp_wb  = 1 << t;
      exp_mask = 4'b1100;
      chk("R5", "res", res, exp_res);
      chk("R6", "n", n, (exp_res >= 128) ? 1 : 0);
      chk("R6", "z", z, (exp_res == 0) ? 1 : 0);
      chk("R6", "fmask", fmask, exp_mask);
      chk("R7", "wb", wb, exp_wb);
    end else begin
      chk("R8", "wb", wb, 0);
      chk("R8", "fmask", fmask, 0);
    end
  endtask

  initial begin
    int opnds[6];
    rst_n = 1'b0;
    op = 2'b00; tgt = 2'b00; acc = 8'h11; xr = 8'h22; yr = 8'h33; mem = 8'h44;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8", "reset_wb", wb, 0);
    chk("R8", "reset_fmask", fmask, 0);
    rst_n = 1'b1;

    // spot values: 123 vs 124 sets N; dec of 1 sets Z; inc 0x7F sets N
    apply(1, 0, 123, 5, 6, 124);
    apply(3, 1, 9, 1, 7, 0);
    apply(2, 2, 9, 8, 8'h7f, 0);

    for (int t = 0; t < 4; t++) begin
      for (int v = 0; v < 256; v++) begin
        int a, x, y, m;
        a = (v + 17) & 255; x = (v + 85) & 255; y = (v + 170) & 255; m = (v + 51) & 255;
        if (t == 0) a = v; else if (t == 1) x = v; else if (t == 2) y = v; else m = v;
        apply(2, t, a, x, y, m);
        apply(3, t, a, x, y, m);
      end
    end

    for (int t = 0; t < 3; t++) begin
      for (int v = 0; v < 256; v++) begin
        int a, x, y;
        opnds[0] = v; opnds[1] = (v + 1) & 255; opnds[2] = (v + 255) & 255;
        opnds[3] = 0; opnds[4] = 128; opnds[5] = 255;
        a = (v + 99) & 255; x = (v + 13) & 255; y = (v + 200) & 255;
        if (t == 0) a = v; else if (t == 1) x = v; else y = v;
        for (int k = 0; k < 6; k++) apply(1, t, a, x, y, opnds[k]);
      end
    end

    for (int v = 0; v < 256; v += 15) begin
      apply(1, 3, v, v, v, v);
      apply(0, v & 3, v, 255 - v, v ^ 85, v);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule